// File: doc/BRIEF.md
# Slow-Peripheral Enable-Clock Bridge

This block sits between a fast bus master that runs handshaked, strobe-driven accesses and a set of slow peripherals that all move data on one shared enable clock. From the system clock it makes that enable clock, which is high for a few cycles and low for a few more. The enable clock keeps running whether or not an access is in progress.

When the master asserts its address strobe and the addressed peripheral pulls its valid-peripheral reply low, the bridge holds the access. It waits for the enable clock's low phase that comes just before a high phase. It then drives its valid-memory-address strobe low, so the peripheral knows the transfer may proceed. The data moves on the falling edge of the enable clock that ends that high phase. One cycle later the bridge releases the strobe and gives a one-cycle completion pulse. If the peripheral never replies, a timeout ends the access with an error pulse and no transfer.

The master keeps its strobe low until it sees the completion or error pulse. It then releases the strobe, and only after that is a new access accepted.

Top module: `legacy_sync_bridge`

## Requirements
- R1: After reset the enable clock `e_clk` is high for the first 4 cycles, then low for 6, and repeats with a period of 10 system clocks for as long as the block runs.
- R2: With no access in progress, `vma_n` stays high (1) and `done` and `err` stay low.
- R3: `vma_n` falls only in a cycle where `e_clk` is low and `e_clk` is high in the next cycle, so it leads the transfer's high phase by one cycle.
- R4: For a read (`rd_wr`=1), `rdata` takes the value `per_rdata` held in the last cycle of that high phase, which is the edge where `e_clk` falls. `rdata` does not change at any other time.
- R5: `vma_n` is still low in the first cycle after `e_clk` falls and is high from the cycle after that.
- R6: `done` is a single-cycle pulse in the cycle where `vma_n` has just returned high.
- R7: If `vpa_n` stays high for 64 cycles after the access is accepted, `err` pulses for one cycle, on the 65th clock edge after `as_n` is first sampled low. In that case `vma_n` never falls and `rdata` is unchanged.
- R8: During an access, `per_rw` and `per_wdata` hold the `rd_wr` and `wdata` values sampled when the access was accepted. `per_rw`=0 means a write, and a write leaves `rdata` unchanged.
- R9: After `done` or `err`, no new access starts until `as_n` has been seen high. Holding `as_n` and `vpa_n` low gives no second `vma_n` pulse.
- R10: If `as_n` returns high before `vpa_n` replies, the access is dropped: no `err`, no `vma_n`, no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Master address strobe, active low |
| rd_wr | input | 1 | Master direction, 1 = read, 0 = write |
| wdata | input | DW | Master write data |
| vpa_n | input | 1 | Peripheral reply, active low |
| per_rdata | input | DW | Data driven by the peripheral |
| e_clk | output | 1 | Enable clock for the slow peripherals |
| vma_n | output | 1 | Transfer-go strobe to the peripheral, active low |
| per_rw | output | 1 | Latched direction toward the peripheral |
| per_wdata | output | DW | Latched write data toward the peripheral |
| rdata | output | DW | Read data captured from the peripheral |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle no-reply pulse |

## Verification
The bench builds the block with its defaults: a 4-high, 6-low enable clock, a 64-cycle reply timeout and 8-bit data. With a period this short, every phase relation between the strobe, the reply and the enable clock can be seen within a few dozen cycles. The full timeout fits in under a hundred cycles, so the exact error cycle can be checked on both sides of the boundary. Changing the peripheral data on every cycle of the high phase shows which edge the capture uses.

// File: rtl/legacy_sync_bridge.sv
module legacy_sync_bridge #(
  parameter int E_HIGH  = 4,
  parameter int E_LOW   = 6,
  parameter int TIMEOUT = 64,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_n,
  input  logic          rd_wr,
  input  logic [DW-1:0] wdata,
  input  logic          vpa_n,
  input  logic [DW-1:0] per_rdata,
  output logic          e_clk,
  output logic          vma_n,
  output logic          per_rw,
  output logic [DW-1:0] per_wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          err
);
  localparam int PERIOD = E_HIGH + E_LOW;
  localparam int EW = $clog2(PERIOD);
  localparam int TW = $clog2(TIMEOUT);
  localparam logic [EW-1:0] E_LAST  = EW'(PERIOD - 1);
  localparam logic [EW-1:0] E_PRE   = EW'(PERIOD - 2);
  localparam logic [EW-1:0] E_FALL  = EW'(E_HIGH - 1);
  localparam logic [TW-1:0] T_LAST  = TW'(TIMEOUT - 1);

  typedef enum logic [2:0] {IDLE, WAIT_VPA, SYNC, XFER, TAIL, FIN, FAIL, WAIT_AS} st_t;

  st_t           st;
  logic [EW-1:0] ecnt;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              ecnt <= '0;
    else if (ecnt == E_LAST) ecnt <= '0;
    else                     ecnt <= ecnt + 1'b1;
  end

  assign e_clk = ecnt < EW'(E_HIGH);
  assign vma_n = !(st == XFER || st == TAIL);
  assign done  = st == FIN;
  assign err   = st == FAIL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      tcnt      <= '0;
      per_rw    <= 1'b1;
      per_wdata <= '0;
      rdata     <= '0;
    end else begin
      case (st)
        IDLE: if (!as_n) begin
          st        <= WAIT_VPA;
          tcnt      <= '0;
          per_rw    <= rd_wr;
          per_wdata <= wdata;
        end
        WAIT_VPA:
          if (as_n)               st <= IDLE;
          else if (!vpa_n)        st <= SYNC;
          else if (tcnt == T_LAST) st <= FAIL;
          else                    tcnt <= tcnt + 1'b1;
        SYNC: if (ecnt == E_PRE) st <= XFER;
        XFER: if (ecnt == E_FALL) begin
          if (per_rw) rdata <= per_rdata;
          st <= TAIL;
        end
        TAIL:    st <= FIN;
        FIN:     st <= WAIT_AS;
        FAIL:    st <= WAIT_AS;
        WAIT_AS: if (as_n) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  a_r3_vma_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vma_n) |-> !e_clk);
  a_r3_rise_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vma_n) |=> $rose(e_clk));
  a_r5_release_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vma_n) |-> !e_clk && !$past(e_clk) && $past(e_clk, 2));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_after_vma: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(vma_n));
  a_r7_err_no_vma: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> vma_n && $past(vma_n));
  a_r2_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));
  a_r4_rdata_only_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $fell(e_clk) && !vma_n);
endmodule

// File: tb/legacy_sync_bridge_test.sv
module legacy_sync_bridge_test;
  localparam int DW = 8;
  logic clk = 0, rst_n = 0, as_n = 1, rd_wr = 1, vpa_n = 1;
  logic [DW-1:0] wdata = '0, per_rdata = '0;
  logic e_clk, vma_n, per_rw, done, err;
  logic [DW-1:0] per_wdata, rdata;
  int checks = 0, fails = 0;
  bit finished = 0;

  legacy_sync_bridge #(.E_HIGH(4), .E_LOW(6), .TIMEOUT(64), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .rd_wr(rd_wr), .wdata(wdata),
    .vpa_n(vpa_n), .per_rdata(per_rdata), .e_clk(e_clk), .vma_n(vma_n),
    .per_rw(per_rw), .per_wdata(per_wdata), .rdata(rdata), .done(done), .err(err));

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic test_reset_and_e();
    rst_n = 0;
    repeat (3) tick();
    chk("R2 reset vma_n", vma_n, 1);
    chk("R2 reset done", done, 0);
    chk("R2 reset err", err, 0);
    rst_n = 1;
    for (int i = 0; i < 30; i++) begin
      chk("R1 e_clk pattern", e_clk, (i % 10) < 4);
      if (vma_n !== 1'b1 || done || err) chk("R2 idle outputs", {vma_n, done, err}, 3'b100);
      tick();
    end
  endtask

  task automatic wait_vma(output bit ok);
    ok = 0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (!vma_n) begin ok = 1; break; end
    end
  endtask

  task automatic do_access(input logic rw, input logic [DW-1:0] wd, input logic [DW-1:0] base,
                           input logic [DW-1:0] exp_rd);
    bit ok;
    rd_wr = rw; wdata = wd; vpa_n = 0; as_n = 0;
    wait_vma(ok);
    chk("R3 vma asserted", ok, 1);
    chk("R3 e low at vma fall", e_clk, 0);
    chk("R8 per_rw latched", per_rw, rw);
    chk("R8 per_wdata latched", per_wdata, wd);
    rd_wr = ~rw; wdata = ~wd;
    for (int k = 0; k < 4; k++) begin
      tick();
      per_rdata = base + DW'(k);
      chk("R3 e high during transfer", e_clk, 1);
      chk("R3 vma held", vma_n, 0);
    end
    tick();
    per_rdata = 8'hEE;
    chk("R5 e fell", e_clk, 0);
    chk("R5 vma still low", vma_n, 0);
    chk("R4 rdata captured", rdata, exp_rd);
    chk("R6 no early done", done, 0);
    chk("R8 per_rw held", per_rw, rw);
    tick();
    chk("R5 vma released", vma_n, 1);
    chk("R6 done pulse", done, 1);
    tick();
    chk("R6 done single", done, 0);
    vpa_n = 1;
    for (int i = 0; i < 25; i++) begin
      tick();
      if (!vma_n) chk("R9 no second access", vma_n, 1);
    end
    chk("R9 held strobe idle", {vma_n, done}, 2'b10);
    as_n = 1; tick(); tick();
  endtask

  task automatic test_read();  do_access(1'b1, 8'h5A, 8'h30, 8'h33); endtask
  task automatic test_write(); do_access(1'b0, 8'hC3, 8'h70, 8'h33); endtask

  task automatic test_timeout();
    logic [DW-1:0] prev = rdata;
    bit vma_seen = 0;
    vpa_n = 1; rd_wr = 1; as_n = 0;
    for (int k = 1; k <= 65; k++) begin
      tick();
      if (!vma_n) vma_seen = 1;
      if (k == 64) chk("R7 no err at 64", err, 0);
      if (k == 65) chk("R7 err at 65", err, 1);
    end
    tick();
    chk("R7 err single", err, 0);
    chk("R7 no vma", vma_seen, 0);
    chk("R7 rdata unchanged", rdata, prev);
    vpa_n = 0;
    for (int i = 0; i < 25; i++) begin
      tick();
      if (!vma_n || err) chk("R9 no restart after err", {vma_n, err}, 2'b10);
    end
    chk("R9 idle after err", vma_n, 1);
    as_n = 1; vpa_n = 1; tick(); tick();
  endtask

  task automatic test_abort();
    bit any = 0;
    as_n = 0; vpa_n = 1;
    repeat (5) tick();
    as_n = 1;
    for (int i = 0; i < 80; i++) begin
      tick();
      if (err || done || !vma_n) any = 1;
    end
    chk("R10 abort silent", any, 0);
  endtask

  initial begin
    tick();
    test_reset_and_e();
    test_read();
    test_write();
    test_timeout();
    test_abort();
    test_read();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule